// File: doc/BRIEF.md
# Dual-Channel GPIO Register Bank

This block is the register core of a memory-mapped general purpose I/O peripheral. It has one or two channels of equal width, from 1 to 32 bits. Each channel keeps a data register and a direction register. These drive the output value and the 3-state enable of an external pad buffer, and they also drive a pair of dedicated output-only pins. The block sits on a simple single-beat register bus with an address, a write strobe with write data, and a read strobe with registered read data.

For each channel, a parameter chooses where input values come from: either the pad's input side or a separate input-only pin. Every external input passes through a two-flop synchronizer before it can be read. Parameters can also make a channel input-only, which removes its direction register and output path, or leave the second channel out completely. Offsets that are not implemented read as zero, and writes to them are dropped.

Top module: `gpio_bank`

## Requirements
- R1: After reset, each channel's data register holds its data reset parameter and its direction register holds its direction reset parameter. The defaults are all zeros for data and all ones for direction. The `chN_dout`, `chN_pad_o`, `chN_dir` and `chN_pad_t` pins show these values.
- R2: A write at byte offset 0x0 loads channel 1's data register. `ch1_dout` and `ch1_pad_o` show the new value from the cycle after the write. No other bus access changes them.
- R3: A write at byte offset 0x4 loads channel 1's direction register, which appears on `ch1_dir` and `ch1_pad_t` the cycle after. Bit value 1 means input (pad driver off, pad_t=1). Bit value 0 means output.
- R4: A read strobe returns data in `bus_rdata` one cycle later, zero-extended to 32 bits. In any cycle that follows a cycle without a read strobe, `bus_rdata` is zero. A data-register read returns the synchronized input for bits whose direction is 1, and the stored data bit for bits whose direction is 0.
- R5: The input source of each channel is set by a parameter. With BIDIR set, the input comes from `chN_pad_i`. With BIDIR clear, it comes from `chN_in_i`. The other source is ignored.
- R6: Each input passes through two flops. Suppose an input changes before clock edge k. A data read sampled at edge k+1 still returns the old value, and a read sampled at edge k+2 returns the new value.
- R7: Channel 2 works the same way as channel 1. Its data register is at offset 0x8 and its direction register at 0xC, and it has its own reset parameters.
- R8: A byte address whose two low bits are not zero is unimplemented. A read of it returns zero, and a write to it changes no register.
- R9: An input-only channel drives `chN_dout`, `chN_dir` and `chN_pad_o` low and `chN_pad_t` all ones, whatever is written. Its direction offset reads zero, and its data offset reads the synchronized input.
- R10: When dual mode is off, channel 2's pins are tied off the same way as an input-only channel. Offsets 0x8 and 0xC read zero, and writes to them are dropped.
- R11: If a read and a write hit the same register in the same cycle, the read returns the value from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address within the peripheral |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_rd |
| ch1_pad_i | input | W | Channel 1 pad input side |
| ch1_in_i | input | W | Channel 1 dedicated input pins |
| ch1_pad_o | output | W | Channel 1 pad output value |
| ch1_pad_t | output | W | Channel 1 pad 3-state control, 1 = high impedance |
| ch1_dout | output | W | Channel 1 output-only data pins |
| ch1_dir | output | W | Channel 1 direction pins |
| ch2_pad_i | input | W | Channel 2 pad input side |
| ch2_in_i | input | W | Channel 2 dedicated input pins |
| ch2_pad_o | output | W | Channel 2 pad output value |
| ch2_pad_t | output | W | Channel 2 pad 3-state control, 1 = high impedance |
| ch2_dout | output | W | Channel 2 output-only data pins |
| ch2_dir | output | W | Channel 2 direction pins |

## Verification
A read and a write can land on the same register in one cycle. The bench provokes this by raising both strobes on the channel 1 direction offset with new write data. The result passes only if the returned word equals the old direction value and `ch1_dir` shows the new value one cycle later. A second overlap is an input change arriving while reads go back to back. Two consecutive read strobes straddle the synchronizer delay, and the first must return the old pin value while the second returns the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W = 32;

  // register select, taken from byte address bits [3:2]
  typedef enum logic [1:0] {
    SEL_DATA1 = 2'd0,
    SEL_DIR1  = 2'd1,
    SEL_DATA2 = 2'd2,
    SEL_DIR2  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan #(
  parameter int           W        = 8,
  parameter bit           IN_ONLY  = 1'b0,
  parameter bit           BIDIR    = 1'b1,
  parameter logic [W-1:0] DOUT_RST = '0,
  parameter logic [W-1:0] DIR_RST  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_t,
  output logic [W-1:0] dout,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir
);
  logic [W-1:0] raw_in, sync_in;

  // input source selection
  if (BIDIR) begin : g_src_pad
    logic unused_src;
    assign raw_in     = pad_i;
    assign unused_src = ^in_i;
  end else begin : g_src_pin
    logic unused_src;
    assign raw_in     = in_i;
    assign unused_src = ^pad_i;
  end

  gpio_sync #(.W(W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  if (IN_ONLY) begin : g_in_only
    logic unused_wr;
    assign unused_wr = ^{wr_data, wr_dir, wdata};
    assign pad_o   = '0;
    assign pad_t   = '1;
    assign dout    = '0;
    assign dir_o   = '0;
    assign rd_data = sync_in;
    assign rd_dir  = '0;
  end else begin : g_in_out
    logic [W-1:0] data_q, dir_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q <= DOUT_RST;
        dir_q  <= DIR_RST;
      end else begin
        if (wr_data) data_q <= wdata;
        if (wr_dir)  dir_q  <= wdata;
      end
    end

    assign pad_o   = data_q;
    assign pad_t   = dir_q;
    assign dout    = data_q;
    assign dir_o   = dir_q;
    assign rd_data = (dir_q & sync_in) | (~dir_q & data_q);
    assign rd_dir  = dir_q;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          W            = 8,
  parameter int          AW           = 4,
  parameter bit          DUAL         = 1'b1,
  parameter bit          IN_ONLY1     = 1'b0,
  parameter bit          IN_ONLY2     = 1'b0,
  parameter bit          BIDIR1       = 1'b1,
  parameter bit          BIDIR2       = 1'b0,
  parameter logic [31:0] CH1_DOUT_RST = 32'h0000_0000,
  parameter logic [31:0] CH1_DIR_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] CH2_DOUT_RST = 32'h0000_0000,
  parameter logic [31:0] CH2_DIR_RST  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [W-1:0]     ch1_pad_i,
  input  logic [W-1:0]     ch1_in_i,
  output logic [W-1:0]     ch1_pad_o,
  output logic [W-1:0]     ch1_pad_t,
  output logic [W-1:0]     ch1_dout,
  output logic [W-1:0]     ch1_dir,
  input  logic [W-1:0]     ch2_pad_i,
  input  logic [W-1:0]     ch2_in_i,
  output logic [W-1:0]     ch2_pad_o,
  output logic [W-1:0]     ch2_pad_t,
  output logic [W-1:0]     ch2_dout,
  output logic [W-1:0]     ch2_dir
);
  logic             upper_zero, hit;
  reg_sel_e         sel;
  logic [W-1:0]     wval;
  logic [W-1:0]     c1_rd_data, c1_rd_dir, c2_rd_data, c2_rd_dir;
  logic [BUS_W-1:0] rd_word;
  logic             unused_bus;

  if (AW > 4) begin : g_hi_addr
    assign upper_zero = (bus_addr[AW-1:4] == '0);
  end else begin : g_no_hi_addr
    assign upper_zero = 1'b1;
  end

  assign hit        = upper_zero && (bus_addr[1:0] == 2'b00);
  assign sel        = reg_sel_e'(bus_addr[3:2]);
  assign wval       = bus_wdata[W-1:0];
  assign unused_bus = ^bus_wdata;

  gpio_chan #(
    .W(W), .IN_ONLY(IN_ONLY1), .BIDIR(BIDIR1),
    .DOUT_RST(CH1_DOUT_RST[W-1:0]), .DIR_RST(CH1_DIR_RST[W-1:0])
  ) u_ch1 (
    .clk     (clk),
    .rst     (rst),
    .wr_data (bus_wr && hit && sel == SEL_DATA1),
    .wr_dir  (bus_wr && hit && sel == SEL_DIR1),
    .wdata   (wval),
    .pad_i   (ch1_pad_i),
    .in_i    (ch1_in_i),
    .pad_o   (ch1_pad_o),
    .pad_t   (ch1_pad_t),
    .dout    (ch1_dout),
    .dir_o   (ch1_dir),
    .rd_data (c1_rd_data),
    .rd_dir  (c1_rd_dir)
  );

  if (DUAL) begin : g_ch2
    gpio_chan #(
      .W(W), .IN_ONLY(IN_ONLY2), .BIDIR(BIDIR2),
      .DOUT_RST(CH2_DOUT_RST[W-1:0]), .DIR_RST(CH2_DIR_RST[W-1:0])
    ) u_ch2 (
      .clk     (clk),
      .rst     (rst),
      .wr_data (bus_wr && hit && sel == SEL_DATA2),
      .wr_dir  (bus_wr && hit && sel == SEL_DIR2),
      .wdata   (wval),
      .pad_i   (ch2_pad_i),
      .in_i    (ch2_in_i),
      .pad_o   (ch2_pad_o),
      .pad_t   (ch2_pad_t),
      .dout    (ch2_dout),
      .dir_o   (ch2_dir),
      .rd_data (c2_rd_data),
      .rd_dir  (c2_rd_dir)
    );
  end else begin : g_no_ch2
    logic unused_ch2;
    assign unused_ch2 = ^{ch2_pad_i, ch2_in_i};
    assign ch2_pad_o  = '0;
    assign ch2_pad_t  = '1;
    assign ch2_dout   = '0;
    assign ch2_dir    = '0;
    assign c2_rd_data = '0;
    assign c2_rd_dir  = '0;
  end

  // read multiplexer, sampled with the values from before any same-cycle write
  always_comb begin
    rd_word = '0;
    if (bus_rd && hit) begin
      unique case (sel)
        SEL_DATA1: rd_word = BUS_W'(c1_rd_data);
        SEL_DIR1:  rd_word = BUS_W'(c1_rd_dir);
        SEL_DATA2: rd_word = BUS_W'(c2_rd_data);
        SEL_DIR2:  rd_word = BUS_W'(c2_rd_dir);
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int W        = 8,
  parameter int AW       = 4,
  parameter bit DUAL     = 1'b1,
  parameter bit IN_ONLY1 = 1'b0,
  parameter bit IN_ONLY2 = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic [W-1:0]  ch1_dout,
  input logic [W-1:0]  ch1_dir,
  input logic [W-1:0]  ch2_dout,
  input logic [W-1:0]  ch2_dir
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata, ch2_dout, ch2_dir};

  // R4: no strobe, no data
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  // R8: misaligned addresses read zero
  p_misaligned_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  if (!IN_ONLY1) begin : g_ch1_checks
    p_data_wr_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == AW'(0)) |=> ch1_dout == $past(bus_wdata[W-1:0]));

    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && bus_addr == AW'(0)) |=> $stable(ch1_dout));

    p_dir_wr_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == AW'(4)) |=> ch1_dir == $past(bus_wdata[W-1:0]));

    p_rd_before_wr_r11: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_wr && bus_addr == AW'(4)) |=> bus_rdata[W-1:0] == $past(ch1_dir));
  end

  if (DUAL && !IN_ONLY2) begin : g_ch2_checks
    p_ch2_data_wr_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == AW'(8)) |=> ch2_dout == $past(bus_wdata[W-1:0]));
  end

  if (!DUAL) begin : g_no_ch2_checks
    p_ch2_absent_read_r10: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr[3] && bus_addr[1:0] == 2'b00) |=> bus_rdata == '0);
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .W(W), .AW(AW), .DUAL(DUAL), .IN_ONLY1(IN_ONLY1), .IN_ONLY2(IN_ONLY2)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ch1_dout  (ch1_dout),
  .ch1_dir   (ch1_dir),
  .ch2_dout  (ch2_dout),
  .ch2_dir   (ch2_dir)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [W-1:0] p1_pad = '0, p1_in = '0, p2_pad = '0, p2_in = '0;

  logic [31:0]  m_rdata, a_rdata;
  logic [W-1:0] m1_po, m1_pt, m1_do, m1_di, m2_po, m2_pt, m2_do, m2_di;
  logic [W-1:0] a1_po, a1_pt, a1_do, a1_di, a2_po, a2_pt, a2_do, a2_di;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(
    .W(W), .AW(4), .DUAL(1'b1), .IN_ONLY1(1'b0), .IN_ONLY2(1'b0),
    .BIDIR1(1'b1), .BIDIR2(1'b0),
    .CH2_DOUT_RST(32'h0000_00A5), .CH2_DIR_RST(32'h0000_000F)
  ) u_gpio_bank (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(m_rdata),
    .ch1_pad_i(p1_pad), .ch1_in_i(p1_in), .ch1_pad_o(m1_po), .ch1_pad_t(m1_pt),
    .ch1_dout(m1_do), .ch1_dir(m1_di),
    .ch2_pad_i(p2_pad), .ch2_in_i(p2_in), .ch2_pad_o(m2_po), .ch2_pad_t(m2_pt),
    .ch2_dout(m2_do), .ch2_dir(m2_di)
  );

  // alternate build: single channel, channel 1 input-only from dedicated pins
  gpio_bank #(
    .W(W), .AW(4), .DUAL(1'b0), .IN_ONLY1(1'b1), .BIDIR1(1'b0)
  ) u_gpio_bank_alt (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(a_rdata),
    .ch1_pad_i(p1_pad), .ch1_in_i(p1_in), .ch1_pad_o(a1_po), .ch1_pad_t(a1_pt),
    .ch1_dout(a1_do), .ch1_dir(a1_di),
    .ch2_pad_i(p2_pad), .ch2_in_i(p2_in), .ch2_pad_o(a2_po), .ch2_pad_t(a2_pt),
    .ch2_dout(a2_do), .ch2_dir(a2_di)
  );

  typedef struct {
    logic [31:0] exp;
    bit          alt;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  logic     rd_q = 1'b0;

  always @(posedge clk) rd_q <= rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item for every read strobe seen at the last edge
  always @(negedge clk) begin
    if (rd_q && !done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: read data without expected item, actual=%h expected=none", m_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, it.alt ? a_rdata : m_rdata, it.exp);
      end
    end
  end

  task automatic push_exp(input logic [31:0] e, input bit alt, input string tag);
    rd_item_t it;
    it.exp = e; it.alt = alt; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [31:0] e, input bit alt, input string tag);
    @(negedge clk); addr = a; rd = 1'b1; push_exp(e, alt, tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 ch1_dout", 32'(m1_do), 32'h00);
    check("R1 ch1_dir",  32'(m1_di), 32'hFF);
    check("R1 ch1_pad_t", 32'(m1_pt), 32'hFF);
    check("R7 ch2 reset dout", 32'(m2_do), 32'hA5);
    check("R7 ch2 reset dir",  32'(m2_di), 32'h0F);
    check("R4 rdata idle", m_rdata, 32'h0);
    rd_reg(4'h4, 32'hFF, 1'b0, "R1 dir1 read");

    // R3 direction
    wr_reg(4'h4, 32'h0000_000F);
    check("R3 ch1_dir", 32'(m1_di), 32'h0F);
    check("R3 ch1_pad_t", 32'(m1_pt), 32'h0F);
    // R2 data
    wr_reg(4'h0, 32'h0000_003C);
    check("R2 ch1_dout", 32'(m1_do), 32'h3C);
    check("R2 ch1_pad_o", 32'(m1_po), 32'h3C);

    // R4 / R5 mixed read, channel 1 from pad
    p1_pad = 8'hA6; p1_in = 8'h59; p2_pad = 8'hFF; p2_in = 8'h03;
    idle(3);
    rd_reg(4'h0, 32'h36, 1'b0, "R4 R5 ch1 mixed read");
    // R5 channel 2 from dedicated pins
    rd_reg(4'h8, 32'hA3, 1'b0, "R5 ch2 mixed read");

    // R7 channel 2 registers
    wr_reg(4'hC, 32'h0000_00F0);
    check("R7 ch2_dir", 32'(m2_di), 32'hF0);
    check("R7 ch2_pad_t", 32'(m2_pt), 32'hF0);
    wr_reg(4'h8, 32'h0000_0011);
    check("R7 ch2_dout", 32'(m2_do), 32'h11);
    rd_reg(4'h8, 32'h01, 1'b0, "R7 ch2 data read");
    rd_reg(4'hC, 32'hF0, 1'b0, "R7 ch2 dir read");

    // R6 synchronizer latency, back-to-back reads
    @(negedge clk); p1_pad = 8'hA9;
    @(negedge clk); addr = 4'h0; rd = 1'b1; push_exp(32'h36, 1'b0, "R6 old value at first edge");
    @(negedge clk); push_exp(32'h39, 1'b0, "R6 new value at second edge");
    @(negedge clk); rd = 1'b0;

    // R8 misaligned access
    rd_reg(4'h2, 32'h0, 1'b0, "R8 misaligned read");
    wr_reg(4'h1, 32'h0000_00FF);
    check("R8 dout unchanged", 32'(m1_do), 32'h3C);
    check("R8 dir unchanged", 32'(m1_di), 32'h0F);
    rd_reg(4'h0, 32'h39, 1'b0, "R8 data unchanged");

    // R11 read and write of the same register in one cycle
    @(negedge clk); addr = 4'h4; wdata = 32'h0000_00FF; wr = 1'b1; rd = 1'b1;
    push_exp(32'h0F, 1'b0, "R11 read returns old dir");
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    check("R11 write took effect", 32'(m1_di), 32'hFF);

    // R4 all outputs: read returns stored data regardless of pad
    wr_reg(4'h4, 32'h0);
    check("R3 pad_t all output", 32'(m1_pt), 32'h00);
    rd_reg(4'h0, 32'h3C, 1'b0, "R4 all-output read");

    // R9 input-only channel in alternate build
    check("R9 alt dout", 32'(a1_do), 32'h00);
    check("R9 alt dir", 32'(a1_di), 32'h00);
    check("R9 alt pad_o", 32'(a1_po), 32'h00);
    check("R9 alt pad_t", 32'(a1_pt), 32'hFF);
    rd_reg(4'h0, 32'h59, 1'b1, "R9 R5 alt input read from dedicated pins");
    rd_reg(4'h4, 32'h00, 1'b1, "R9 alt dir read");

    // R10 absent channel 2
    wr_reg(4'h8, 32'h0000_00FF);
    wr_reg(4'hC, 32'h0000_0000);
    check("R10 ch2 dout", 32'(a2_do), 32'h00);
    check("R10 ch2 dir", 32'(a2_di), 32'h00);
    check("R10 ch2 pad_o", 32'(a2_po), 32'h00);
    check("R10 ch2 pad_t", 32'(a2_pt), 32'hFF);
    rd_reg(4'h8, 32'h0, 1'b1, "R10 ch2 data read");
    rd_reg(4'hC, 32'h0, 1'b1, "R10 ch2 dir read");

    idle(3);
    check("R4 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule